// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Sequencer

This block lets a clocked host write words into one port of an external asynchronous static RAM. The host offers an address, a 9-bit data word and two per-request options through a valid/ready handshake. The sequencer then runs one full write cycle on the memory pins. It drives chip-enable, the read/write strobe, output-enable, the address and the data bus. The data bus is given as a value plus a drive-enable, so that the pad ring can build the tristate buffer.

All phase lengths are whole clock counts. They are derived at elaboration from the clock period and a speed-grade parameter. Each nanosecond minimum becomes a count by ceiling division, and every count is at least one cycle. The grades are:

| Grade | Cycle (ns) | Pulse (ns) | Data setup (ns) | Output-disable (ns) |
|-------|------------|------------|-----------------|---------------------|
| 0     | 25         | 20         | 12              | 10                  |
| 1     | 35         | 30         | 20              | 15                  |
| 2     | 45         | 35         | 20              | 20                  |
| 3     | 55         | 40         | 20              | 30                  |

A request can ask for output-enable to stay low during the write. In that case the strobe is stretched so that the memory's own drivers are off before data is driven. A request can also ask for the extra arbitration delay that is needed when the memory is used as a slave in a master/slave arrangement. In that case the strobe falls only once that delay has passed.

Top module: `sram_wr_seq`

## Requirements
- R1: Out of reset, and whenever idle, `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` reads 0 from the next cycle until the cycle ends. Requests and field changes offered while busy are ignored: the pins keep the accepted address and data.
- R3: Setup phase: `mem_ce_n` falls on the edge after acceptance while `mem_we_n` stays 1. This lasts 1 cycle, or `ceil(ARB_NS/period)` cycles when `req_arb_wait` was 1.
- R4: `mem_addr` equals the accepted address and stays unchanged from the fall of `mem_ce_n` until the cycle ends.
- R5: With `req_oe_low`=0 the strobe (`mem_we_n`=0) lasts the pulse count, which is 2 cycles at grade 0 with a 10 ns clock.
- R6: With `req_oe_low`=1 the strobe lasts max(pulse, output-disable + data setup) counts, which is 3 cycles at grade 0 with a 10 ns clock. `mem_oe_n` is 0 from setup through recovery.
- R7: `mem_dq_oe` is 1 only while the strobe is low. It rises with the strobe when `req_oe_low`=0, and an output-disable count later when `req_oe_low`=1. While it is 1, `mem_dq_out` carries the accepted data.
- R8: `mem_ce_n` and `mem_we_n` rise on the same edge. Recovery then lasts max(1, target − setup − pulse) cycles. The target is the cycle count, or the arbitration count plus the pulse count when `req_arb_wait`=1.
- R9: `req_ready` returns to 1 in the cycle after recovery ends. A request held valid at that point is accepted at once, giving back-to-back cycles.
- R10: Every count is the ceiling of its nanosecond value over `CLK_PERIOD_NS`, and never less than 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a write |
| req_ready | output | 1 | Sequencer can accept a write |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_oe_low | input | 1 | Hold output-enable low during this write |
| req_arb_wait | input | 1 | Insert the busy-arbitration delay before the strobe |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_we_n | output | 1 | Memory read/write strobe, low = write |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Value for the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
Writes are run in all four combinations of output-enable held low or high and arbitration wait on or off. This separates the plain pulse from the stretched pulse, and the single-cycle setup from the arbitration setup. It also shows whether the data drive is delayed only when the memory's outputs could still be on. A reference model in the bench compares every pin on every clock against phase boundaries that it computes from the nanosecond figures. A back-to-back run with `req_valid` held high and the fields scrambled mid-cycle shows that busy-time inputs are ignored and that the next cycle starts without a gap.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_RECOVER
    } wseq_state_e;

    // nanoseconds to clock cycles, rounded up, at least one
    function automatic int ns2cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int grade_cycle_ns(input int g);
        case (g)
            0:       return 25;
            1:       return 35;
            2:       return 45;
            default: return 55;
        endcase
    endfunction

    function automatic int grade_pulse_ns(input int g);
        case (g)
            0:       return 20;
            1:       return 30;
            2:       return 35;
            default: return 40;
        endcase
    endfunction

    function automatic int grade_dsetup_ns(input int g);
        return (g == 0) ? 12 : 20;
    endfunction

    function automatic int grade_odis_ns(input int g);
        case (g)
            0:       return 10;
            1:       return 15;
            2:       return 20;
            default: return 30;
        endcase
    endfunction

endpackage

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int GRADE         = 0,
    parameter int ARB_NS        = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_oe_low,
    input  logic req_arb_wait,
    output logic accept,
    output logic req_ready,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic mem_dq_oe
);

    localparam int CYC_WC  = ns2cyc(grade_cycle_ns(GRADE), CLK_PERIOD_NS);
    localparam int CYC_WP  = ns2cyc(grade_pulse_ns(GRADE), CLK_PERIOD_NS);
    localparam int CYC_DW  = ns2cyc(grade_dsetup_ns(GRADE), CLK_PERIOD_NS);
    localparam int CYC_WZ  = ns2cyc(grade_odis_ns(GRADE), CLK_PERIOD_NS);
    localparam int CYC_ARB = ns2cyc(ARB_NS, CLK_PERIOD_NS);

    localparam int SET_N   = 1;
    localparam int SET_A   = CYC_ARB;
    localparam int PUL_HI  = CYC_WP;
    localparam int PUL_LO  = imax(CYC_WP, CYC_WZ + CYC_DW);
    localparam int TGT_N   = CYC_WC;
    localparam int TGT_A   = CYC_ARB + CYC_WP;

    localparam int REC_NH  = imax(1, TGT_N - SET_N - PUL_HI);
    localparam int REC_NL  = imax(1, TGT_N - SET_N - PUL_LO);
    localparam int REC_AH  = imax(1, TGT_A - SET_A - PUL_HI);
    localparam int REC_AL  = imax(1, TGT_A - SET_A - PUL_LO);

    localparam int MAXC    = SET_A + PUL_LO + TGT_N + TGT_A + CYC_WZ;
    localparam int CW      = $clog2(MAXC + 1);

    typedef struct packed {
        wseq_state_e   st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] dcnt;
        logic          oe_low;
        logic          arb;
        logic          ready;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic          drv;
    } seq_t;

    seq_t r_q, r_d;
    logic accept_d;

    always_comb begin
        r_d      = r_q;
        accept_d = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.ready = 1'b1;
                r_d.ce_n  = 1'b1;
                r_d.we_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.drv   = 1'b0;
                if (req_valid) begin
                    accept_d   = 1'b1;
                    r_d.st     = ST_SETUP;
                    r_d.ready  = 1'b0;
                    r_d.ce_n   = 1'b0;
                    r_d.oe_n   = ~req_oe_low;
                    r_d.oe_low = req_oe_low;
                    r_d.arb    = req_arb_wait;
                    r_d.cnt    = req_arb_wait ? CW'(SET_A - 1) : CW'(SET_N - 1);
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_PULSE;
                    r_d.we_n = 1'b0;
                    r_d.cnt  = r_q.oe_low ? CW'(PUL_LO - 1) : CW'(PUL_HI - 1);
                    r_d.dcnt = r_q.oe_low ? CW'(CYC_WZ) : '0;
                    r_d.drv  = ~r_q.oe_low;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_RECOVER;
                    r_d.ce_n = 1'b1;
                    r_d.we_n = 1'b1;
                    r_d.drv  = 1'b0;
                    unique case ({r_q.arb, r_q.oe_low})
                        2'b00:   r_d.cnt = CW'(REC_NH - 1);
                        2'b01:   r_d.cnt = CW'(REC_NL - 1);
                        2'b10:   r_d.cnt = CW'(REC_AH - 1);
                        default: r_d.cnt = CW'(REC_AL - 1);
                    endcase
                end else begin
                    r_d.cnt  = r_q.cnt - 1'b1;
                    r_d.dcnt = (r_q.dcnt == '0) ? '0 : r_q.dcnt - 1'b1;
                    r_d.drv  = (r_q.dcnt <= CW'(1));
                end
            end
            ST_RECOVER: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_IDLE;
                    r_d.ready = 1'b1;
                    r_d.oe_n  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, dcnt: '0, oe_low: 1'b0, arb: 1'b0,
                     ready: 1'b1, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign accept    = accept_d;
    assign req_ready = r_q.ready;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_dq_oe = r_q.drv;

    // R2: a cycle in progress never advertises readiness
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);
    // R3: the strobe falls only after at least one cycle of chip-enable
    a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (!mem_ce_n && $past(!mem_ce_n)));
    // R8: both enables rise on the same edge
    a_r8_joint_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_ce_n));
    // R7: the bus is driven only inside the strobe
    a_r7_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n));
    // R1: idle keeps output-enable released
    a_r1_idle_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_oe_n && mem_ce_n));

endmodule

// File: rtl/sram_wr_datapath.sv
module sram_wr_datapath #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              mem_ce_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        if (accept) begin
            h_d.addr = req_addr;
            h_d.data = req_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign mem_addr   = h_q.addr;
    assign mem_dq_out = h_q.data;

    // R4: address frozen while the chip is selected
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq #(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 9,
    parameter int CLK_PERIOD_NS = 10,
    parameter int GRADE         = 0,
    parameter int ARB_NS        = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_oe_low,
    input  logic              req_arb_wait,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    logic accept;

    sram_wr_fsm #(
        .CLK_PERIOD_NS(CLK_PERIOD_NS),
        .GRADE        (GRADE),
        .ARB_NS       (ARB_NS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_oe_low  (req_oe_low),
        .req_arb_wait(req_arb_wait),
        .accept      (accept),
        .req_ready   (req_ready),
        .mem_ce_n    (mem_ce_n),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_dq_oe   (mem_dq_oe)
    );

    sram_wr_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .mem_ce_n  (mem_ce_n),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out)
    );

endmodule

// File: tb/sram_wr_seq_test.sv
module sram_wr_seq_test;

    localparam int CLK_NS = 10;
    localparam int ARB    = 20;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [10:0] req_addr;
    logic [8:0]  req_data;
    logic        req_oe_low;
    logic        req_arb_wait;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [10:0] mem_addr;
    logic [8:0]  mem_dq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    sram_wr_seq #(.CLK_PERIOD_NS(CLK_NS), .GRADE(0), .ARB_NS(ARB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_oe_low(req_oe_low),
        .req_arb_wait(req_arb_wait), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe)
    );

    initial clk = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    function automatic int up(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(req_ready == 1'b1, {tag, " ready"}, int'(req_ready), 1);
        chk(mem_ce_n  == 1'b1, {tag, " ce_n"},  int'(mem_ce_n), 1);
        chk(mem_we_n  == 1'b1, {tag, " we_n"},  int'(mem_we_n), 1);
        chk(mem_oe_n  == 1'b1, {tag, " oe_n"},  int'(mem_oe_n), 1);
        chk(mem_dq_oe == 1'b0, {tag, " dq_oe"}, int'(mem_dq_oe), 0);
    endtask

    // Runs one write. Entered and left at a falling edge. req_valid stays 1.
    task automatic run_write(input logic [10:0] a, input logic [8:0] d,
                             input bit oe_low, input bit arb);
        int s, p, tgt, rc, dly, total;
        s     = arb ? up(ARB) : 1;
        p     = oe_low ? mx(up(20), up(10) + up(12)) : up(20);
        tgt   = arb ? up(ARB) + up(20) : up(25);
        rc    = mx(1, tgt - s - p);
        dly   = oe_low ? up(10) : 0;
        total = s + p + rc;
        req_valid    = 1'b1;
        req_addr     = a;
        req_data     = d;
        req_oe_low   = oe_low;
        req_arb_wait = arb;
        chk(req_ready == 1'b1, "R9 ready before accept", int'(req_ready), 1);
        @(posedge clk);
        #1;
        // R2: scrambled fields while busy must be ignored
        req_addr     = ~a;
        req_data     = ~d;
        req_oe_low   = ~oe_low;
        req_arb_wait = ~arb;
        for (int k = 0; k < total; k++) begin
            bit e_ce, e_we, e_drv;
            @(negedge clk);
            e_ce  = (k < s + p) ? 1'b0 : 1'b1;
            e_we  = (k >= s && k < s + p) ? 1'b0 : 1'b1;
            e_drv = (k >= s + dly && k < s + p);
            chk(req_ready == 1'b0, "R2 busy ready", int'(req_ready), 0);
            chk(mem_ce_n == e_ce, "R3/R8 ce_n", int'(mem_ce_n), int'(e_ce));
            chk(mem_we_n == e_we, oe_low ? "R6 we_n" : "R5 we_n", int'(mem_we_n), int'(e_we));
            chk(mem_oe_n == ~oe_low, "R6 oe_n", int'(mem_oe_n), int'(~oe_low));
            chk(mem_dq_oe == e_drv, "R7 dq_oe", int'(mem_dq_oe), int'(e_drv));
            chk(mem_addr == a, "R4 addr", int'(mem_addr), int'(a));
            if (e_drv)
                chk(mem_dq_out == d, "R7 data", int'(mem_dq_out), int'(d));
        end
        @(negedge clk);
        check_idle("R9 return");
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
        req_oe_low = 1'b0; req_arb_wait = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1 idle");
        // R10: counts 25->3, 20->2, 12->2, 10->1 cycles at 10 ns
        run_write(11'h123, 9'h1A5, 1'b0, 1'b0);
        req_valid = 1'b0;
        @(negedge clk);
        check_idle("R1 gap");
        run_write(11'h7FF, 9'h0F0, 1'b1, 1'b0);
        req_valid = 1'b0;
        @(negedge clk);
        run_write(11'h000, 9'h1FF, 1'b0, 1'b1);
        req_valid = 1'b0;
        @(negedge clk);
        run_write(11'h2AA, 9'h155, 1'b1, 1'b1);
        // back-to-back, valid never dropped
        run_write(11'h555, 9'h0AA, 1'b0, 1'b0);
        run_write(11'h3C3, 9'h13C, 1'b1, 1'b0);
        run_write(11'h0F1, 9'h001, 1'b1, 1'b1);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R1 final");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule